// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage element of one programmable-logic macrocell. Static configuration inputs turn it into an edge-triggered D register, an edge-triggered T register or a level-sensitive transparent latch. An input stage in front of the storage node can XOR in an extra term, invert the result, or build the next state of an emulated J-K or S-R flip-flop from two terms. The clock or enable comes from one of several shared block clocks in synchronous mode, or from a private product-term clock in asynchronous mode. Its active edge or level is programmable.

All clock-like inputs are oversampled by the fast system clock `clk`. An active edge or transparent level seen at one `clk` edge updates `q` at that same edge, so `q` shows the result one `clk` cycle after the input changed. Clear and preset terms, and a power-up pulse that loads a configurable initial value, take priority over clocking.

The cell moves no data stream, so it has no valid/ready pair. Every pin is a plain level signal with no handshake and no back-pressure. The configuration pins are meant to be static while the selected clock is active.

Top module: `mc_cell`

## Requirements
- R1: While `rst_n` is low, `q` equals `cfg_pu_set`. A cycle with `pwr_up` high loads `cfg_pu_set` into `q`, whatever the other inputs do.
- R2: With `cfg_kind` 00 or 11 (D register), `q` takes the storage input at an active edge of the selected clock. Without an active edge, `q` holds, even while the storage input changes.
- R3: With `cfg_kind` 01 (T register), an active edge toggles `q` when the storage input is 1 and holds `q` when it is 0.
- R4: With `cfg_kind` 10 (latch), `q` follows the storage input while the selected enable is at its active level. It holds while the enable is at the other level.
- R5: With `cfg_clk_inv` 0, the active edge is rising and the active level is high. With `cfg_clk_inv` 1, the active edge is falling and the active level is low.
- R6: With `cfg_async` 0, only `blk_clk[cfg_clk_sel]` clocks the cell; activity on the other block clocks and on `pt_clk` has no effect. With `cfg_async` 1, only `pt_clk` clocks the cell.
- R7: With `cfg_emul` 00, the storage input is `sum_term ^ cfg_din_inv`. With `cfg_emul` 01, it is `sum_term ^ xor_term ^ cfg_din_inv`.
- R8: With `cfg_emul` 10 and a D register, J=`sum_term` and K=`xor_term`. JK 00 holds `q`, 01 clears it, 10 sets it, 11 toggles it.
- R9: With `cfg_emul` 11 and a D register, S=`sum_term` and R=`xor_term`. S alone sets `q`, R alone clears it, both together clear it, and neither holds it.
- R10: `ar_term` high clears `q` and `ap_term` high presets it, both at the next `clk` edge and regardless of the clock. When both are high, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset; loads the power-up value |
| cfg_kind | input | 2 | Storage type: 00 D register, 01 T register, 10 latch, 11 D register |
| cfg_emul | input | 2 | Input stage: 00 plain, 01 XOR, 10 J-K, 11 S-R |
| cfg_din_inv | input | 1 | Inverts the storage input in the plain and XOR input modes |
| cfg_async | input | 1 | 0 selects a block clock, 1 selects the product-term clock |
| cfg_clk_sel | input | 2 | Index of the block clock used in synchronous mode |
| cfg_clk_inv | input | 1 | Clock/enable polarity: 0 rising/high, 1 falling/low |
| cfg_pu_set | input | 1 | Initial value: 0 reset, 1 preset |
| blk_clk | input | 4 | Shared block clocks |
| pt_clk | input | 1 | Private product-term clock |
| sum_term | input | 1 | Main logic term (D, T, J or S) |
| xor_term | input | 1 | Extra term (XOR operand, K or R) |
| ar_term | input | 1 | Clear term |
| ap_term | input | 1 | Preset term |
| pwr_up | input | 1 | Power-up pulse that loads `cfg_pu_set` |
| q | output | 1 | Stored value |

## Verification
Each storage kind is driven with directed sequences that separate edge from level behaviour. In the D and latch tests, the data changes while the clock is held high, which tells a register apart from a transparent latch. The polarity test inverts the clock phase, which tells rising from falling. The source-select tests wiggle the unused block clocks and the product-term clock, which shows the selected source is the only one that acts. All four J-K and S-R input pairs are applied, including the toggle and conflict cases. Random configurations then mix random clock levels with sparse clear, preset and power-up pulses, which exposes priority mistakes between initialization and clocking.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    KIND_DREG     = 2'b00,
    KIND_TREG     = 2'b01,
    KIND_LATCH    = 2'b10,
    KIND_DREG_ALT = 2'b11
  } store_kind_e;

  typedef enum logic [1:0] {
    EMUL_PLAIN = 2'b00,
    EMUL_XOR   = 2'b01,
    EMUL_JK    = 2'b10,
    EMUL_SR    = 2'b11
  } emul_mode_e;

endpackage

// File: rtl/mc_clk_front.sv
module mc_clk_front #(
  parameter int NUM_BLK_CLK = 4,
  parameter int SEL_W       = (NUM_BLK_CLK > 1) ? $clog2(NUM_BLK_CLK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   pt_clk,
  input  logic                   async_mode,
  input  logic [SEL_W-1:0]       clk_sel,
  input  logic                   clk_inv,
  output logic                   act_edge,
  output logic                   act_level
);
  localparam int SRC_CNT = NUM_BLK_CLK + 1;
  localparam int IDX_W   = $clog2(SRC_CNT);

  logic [SRC_CNT-1:0] lvl_now;
  logic [SRC_CNT-1:0] lvl_prev;
  logic [SRC_CNT-1:0] lvl_act;
  logic [SRC_CNT-1:0] edge_vec;
  logic [IDX_W-1:0]   src_idx;

  assign lvl_now = {pt_clk, blk_clk};

  // every source keeps its own history so a selection change never fakes an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl_now;
  end

  generate
    for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
      assign lvl_act[g]  = lvl_now[g] ^ clk_inv;
      assign edge_vec[g] = lvl_act[g] & ~(lvl_prev[g] ^ clk_inv);
    end
  endgenerate

  always_comb begin
    if (async_mode) src_idx = IDX_W'(NUM_BLK_CLK);
    else            src_idx = IDX_W'(clk_sel);
  end

  assign act_edge  = edge_vec[src_idx];
  assign act_level = lvl_act[src_idx];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> (!act_edge || !$stable({clk_inv, src_idx}))); // R5

endmodule

// File: rtl/mc_din_stage.sv
module mc_din_stage (
  input  mc_pkg::emul_mode_e emul,
  input  logic               din_inv,
  input  logic               sum_term,
  input  logic               xor_term,
  input  logic               q_now,
  output logic               din
);
  import mc_pkg::*;

  always_comb begin
    unique case (emul)
      EMUL_PLAIN: din = sum_term ^ din_inv;
      EMUL_XOR:   din = sum_term ^ xor_term ^ din_inv;
      EMUL_JK:    din = (sum_term & ~q_now) | (~xor_term & q_now);
      EMUL_SR:    din = ~xor_term & (sum_term | q_now);
      default:    din = q_now;
    endcase
  end

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic                clk,
  input  logic                rst_n,
  input  mc_pkg::store_kind_e kind,
  input  logic                pu_set,
  input  logic                pwr_up,
  input  logic                ar_term,
  input  logic                ap_term,
  input  logic                act_edge,
  input  logic                act_level,
  input  logic                din,
  output logic                q
);
  import mc_pkg::*;

  logic q_r;
  logic init_any;

  assign init_any = pwr_up | ar_term | ap_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= pu_set;
    else if (pwr_up)  q_r <= pu_set;
    else if (ar_term) q_r <= 1'b0;
    else if (ap_term) q_r <= 1'b1;
    else begin
      unique case (kind)
        KIND_TREG:  if (act_edge)  q_r <= q_r ^ din;
        KIND_LATCH: if (act_level) q_r <= din;
        default:    if (act_edge)  q_r <= din;
      endcase
    end
  end

  assign q = q_r;

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (q == $past(pu_set))); // R1

  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_term && !pwr_up) |=> !q); // R10

  AST_PRESET_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_term && !ar_term && !pwr_up) |=> q); // R10

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_any && !act_edge && !(kind == KIND_LATCH && act_level)) |=> $stable(q)); // R2

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_any && kind == KIND_TREG && act_edge && din) |=> (q != $past(q))); // R3

endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NUM_BLK_CLK = 4,
  parameter int SEL_W       = (NUM_BLK_CLK > 1) ? $clog2(NUM_BLK_CLK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_kind,
  input  logic [1:0]             cfg_emul,
  input  logic                   cfg_din_inv,
  input  logic                   cfg_async,
  input  logic [SEL_W-1:0]       cfg_clk_sel,
  input  logic                   cfg_clk_inv,
  input  logic                   cfg_pu_set,
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   pt_clk,
  input  logic                   sum_term,
  input  logic                   xor_term,
  input  logic                   ar_term,
  input  logic                   ap_term,
  input  logic                   pwr_up,
  output logic                   q
);
  import mc_pkg::*;

  logic act_edge;
  logic act_level;
  logic din;
  logic q_int;

  mc_clk_front #(
    .NUM_BLK_CLK (NUM_BLK_CLK),
    .SEL_W       (SEL_W)
  ) u_clk_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_clk    (blk_clk),
    .pt_clk     (pt_clk),
    .async_mode (cfg_async),
    .clk_sel    (cfg_clk_sel),
    .clk_inv    (cfg_clk_inv),
    .act_edge   (act_edge),
    .act_level  (act_level)
  );

  mc_din_stage u_din_stage (
    .emul     (emul_mode_e'(cfg_emul)),
    .din_inv  (cfg_din_inv),
    .sum_term (sum_term),
    .xor_term (xor_term),
    .q_now    (q_int),
    .din      (din)
  );

  mc_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (store_kind_e'(cfg_kind)),
    .pu_set    (cfg_pu_set),
    .pwr_up    (pwr_up),
    .ar_term   (ar_term),
    .ap_term   (ap_term),
    .act_edge  (act_edge),
    .act_level (act_level),
    .din       (din),
    .q         (q_int)
  );

  assign q = q_int;

endmodule

// File: tb/mc_cell_test.sv
module mc_cell_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_kind, cfg_emul, cfg_clk_sel;
  logic       cfg_din_inv, cfg_async, cfg_clk_inv, cfg_pu_set;
  logic [3:0] blk_clk;
  logic       pt_clk, sum_term, xor_term, ar_term, ap_term, pwr_up;
  logic       q;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  logic m_q;
  logic [4:0] m_prev;

  always #2 clk = ~clk;

  mc_cell uut (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_emul(cfg_emul),
    .cfg_din_inv(cfg_din_inv), .cfg_async(cfg_async), .cfg_clk_sel(cfg_clk_sel),
    .cfg_clk_inv(cfg_clk_inv), .cfg_pu_set(cfg_pu_set), .blk_clk(blk_clk),
    .pt_clk(pt_clk), .sum_term(sum_term), .xor_term(xor_term),
    .ar_term(ar_term), .ap_term(ap_term), .pwr_up(pwr_up), .q(q)
  );

  // storage input from the requirement tables (R7, R8, R9)
  function automatic logic ref_din(logic cur);
    logic v;
    case (cfg_emul)
      2'd0: v = sum_term ^ cfg_din_inv;
      2'd1: v = (sum_term ^ xor_term) ^ cfg_din_inv;
      2'd2: case ({sum_term, xor_term})
              2'b00:   v = cur;
              2'b01:   v = 1'b0;
              2'b10:   v = 1'b1;
              default: v = ~cur;
            endcase
      default: begin
        if (xor_term)      v = 1'b0;
        else if (sum_term) v = 1'b1;
        else               v = cur;
      end
    endcase
    return v;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  // called just after a falling clk edge with inputs applied
  task automatic step(string tag);
    logic [4:0] lvl;
    int         src;
    logic       now_a, was_a, edg, d, e;
    lvl   = {pt_clk, blk_clk};
    src   = cfg_async ? 4 : int'(cfg_clk_sel);
    now_a = lvl[src] ^ cfg_clk_inv;
    was_a = m_prev[src] ^ cfg_clk_inv;
    edg   = now_a & ~was_a;
    d     = ref_din(m_q);
    if (pwr_up)                e = cfg_pu_set;
    else if (ar_term)          e = 1'b0;
    else if (ap_term)          e = 1'b1;
    else if (cfg_kind == 2'b01) e = edg ? (m_q ^ d) : m_q;
    else if (cfg_kind == 2'b10) e = now_a ? d : m_q;
    else                       e = edg ? d : m_q;
    m_prev = lvl;
    @(posedge clk);
    @(negedge clk);
    check(tag, q, e);
    m_q = e;
  endtask

  task automatic pulse(string tag);
    blk_clk[cfg_clk_sel] = 1'b0;
    step(tag);
    blk_clk[cfg_clk_sel] = 1'b1;
    step(tag);
  endtask

  task automatic do_reset(logic pu);
    cfg_pu_set = pu;
    rst_n = 1'b0;
    blk_clk = '0; pt_clk = 1'b0;
    ar_term = 1'b0; ap_term = 1'b0; pwr_up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset value", q, pu);
    rst_n = 1'b1;
    m_q = pu;
    m_prev = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run still busy, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cfg_kind = 2'b00; cfg_emul = 2'b00; cfg_clk_sel = 2'd2;
    cfg_din_inv = 1'b0; cfg_async = 1'b0; cfg_clk_inv = 1'b0;
    sum_term = 1'b0; xor_term = 1'b0;
    @(negedge clk);
    do_reset(1'b1);

    // R2: D register edges, hold while clock static
    sum_term = 0; blk_clk[2] = 1; step("R2 rising edge loads 0");
    sum_term = 1; step("R2 hold while clock high");
    // R6: foreign clocks ignored
    blk_clk[0] = 1; pt_clk = 1; step("R6 other clocks ignored");
    blk_clk[2] = 0; step("R2 falling edge inactive");
    blk_clk[2] = 1; step("R2 rising edge loads 1");

    // R5: falling-edge polarity
    cfg_clk_inv = 1; sum_term = 0; blk_clk[2] = 0; step("R5 falling edge loads");
    sum_term = 1; blk_clk[2] = 1; step("R5 rising edge ignored");
    blk_clk[2] = 0; step("R5 falling edge loads 1");
    cfg_clk_inv = 0;

    // R6: product-term clock in asynchronous mode
    cfg_async = 1; blk_clk = '0; pt_clk = 0; sum_term = 0; step("R6 pt falling ignored");
    blk_clk[2] = 1; step("R6 block clock ignored in async");
    pt_clk = 1; step("R6 pt rising loads");
    cfg_async = 0;

    // R3: T register
    cfg_kind = 2'b01; sum_term = 1;
    pulse("R3 toggle");
    pulse("R3 toggle again");
    sum_term = 0;
    pulse("R3 hold with T=0");

    // R4: latch
    cfg_kind = 2'b10; blk_clk[2] = 1; sum_term = 0; step("R4 transparent 0");
    sum_term = 1; step("R4 transparent 1");
    blk_clk[2] = 0; step("R4 closed");
    sum_term = 0; step("R4 closed holds");
    cfg_clk_inv = 1; step("R5 low-level transparent");
    cfg_clk_inv = 0;

    // R7: XOR and inversion
    cfg_kind = 2'b00; cfg_emul = 2'b01;
    sum_term = 1; xor_term = 1; pulse("R7 xor 1^1");
    sum_term = 1; xor_term = 0; pulse("R7 xor 1^0");
    cfg_emul = 2'b00; cfg_din_inv = 1; pulse("R7 inverted input");
    cfg_din_inv = 0;

    // R8: J-K
    cfg_emul = 2'b10;
    sum_term = 1; xor_term = 0; pulse("R8 JK set");
    sum_term = 0; xor_term = 0; pulse("R8 JK hold");
    sum_term = 1; xor_term = 1; pulse("R8 JK toggle");
    pulse("R8 JK toggle back");
    sum_term = 0; xor_term = 1; pulse("R8 JK clear");

    // R9: S-R
    cfg_emul = 2'b11;
    sum_term = 1; xor_term = 0; pulse("R9 SR set");
    sum_term = 0; xor_term = 0; pulse("R9 SR hold");
    sum_term = 1; xor_term = 1; pulse("R9 SR both clears");
    sum_term = 1; xor_term = 0; pulse("R9 SR set again");
    sum_term = 0; xor_term = 1; pulse("R9 SR clear");

    // R10: clear and preset priority
    cfg_emul = 2'b00; xor_term = 0;
    ar_term = 1; ap_term = 1; step("R10 clear beats preset");
    ar_term = 0; sum_term = 0; pulse("R10 preset beats clock edge");
    ap_term = 0; ar_term = 1; sum_term = 1; pulse("R10 clear beats clock edge");
    ar_term = 0;

    // R1: power-up pulse
    cfg_pu_set = 1; pwr_up = 1; ar_term = 1; step("R1 power-up preset beats clear");
    pwr_up = 0; ar_term = 0; cfg_pu_set = 0; pwr_up = 1; step("R1 power-up reset");
    pwr_up = 0;
    do_reset(1'b0);

    // random configurations mixed with sparse initialization events
    for (int b = 0; b < 80; b++) begin
      cfg_kind = 2'($urandom); cfg_emul = 2'($urandom);
      cfg_clk_sel = 2'($urandom); cfg_din_inv = 1'($urandom);
      cfg_async = 1'($urandom); cfg_clk_inv = 1'($urandom);
      cfg_pu_set = 1'($urandom);
      for (int c = 0; c < 40; c++) begin
        blk_clk  = 4'($urandom);
        pt_clk   = 1'($urandom);
        sum_term = 1'($urandom);
        xor_term = 1'($urandom);
        ar_term  = ($urandom % 16) == 0;
        ap_term  = ($urandom % 16) == 0;
        pwr_up   = ($urandom % 32) == 0;
        if (cfg_kind == 2'b01)      step("R3 random");
        else if (cfg_kind == 2'b10) step("R4 random");
        else if (cfg_emul == 2'b10) step("R8 random");
        else if (cfg_emul == 2'b11) step("R9 random");
        else                        step("R2 random");
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule